// File: doc/BRIEF.md
# Dual-Rate Clock Enable Generator

This block runs entirely on the oscillator clock. It produces single-cycle enable pulses: one for the processor core and six for the peripherals. The peripheral order is timer 0, timer 1, timer 2, serial port, counter array and watchdog. Downstream logic stays on the oscillator clock and advances only in cycles where its enable is high, so no gated or derived clocks exist.

The block has two modes: standard and double-speed.

- In standard mode every consumer runs at half the oscillator rate.
- In double-speed mode the core advances on every oscillator cycle. Each peripheral picks the full or halved rate through its own speed bit.

A change of the global speed bit is applied only at a rising edge of the internal divide-by-two phase, so the core never sees a shortened period. An external power controller drives two inputs. The power-down input freezes everything, including the divider phase. The idle input silences only the core enable.

The configuration register is written through a plain write strobe and is visible on an output. All pins are control or status pins; there is no streaming interface.

Top module: `dual_rate_clken`

## Requirements
- R1: In standard mode the core enable and all six peripheral enables pulse on every second oscillator cycle. The first pulse falls in the first cycle after reset release.
- R2: On reset the configuration register holds zero in bits 7..1, and bit 0 holds the value of `boot_fast_i`. The applied mode starts as double-speed exactly when `boot_fast_i` is high.
- R3: A new value of configuration bit 0 is applied only at the end of a cycle in which the divided phase rises (a halved-rate pulse cycle). Written in a non-pulse cycle, it first shows one more standard-mode cycle without a core pulse.
- R4: In double-speed mode, with power-down and idle low, the core enable is high on every cycle.
- R5: In double-speed mode, peripheral k (bit k+1 of the register, k=0..5 in the order timer 0, timer 1, timer 2, serial port, counter array, watchdog) runs at the halved rate when its bit is 1. When its bit is 0 it pulses every cycle.
- R6: While the applied mode is standard, the peripheral speed bits have no effect, and all peripherals pulse at the halved rate.
- R7: While `pd_i` is high, every enable output is low, and the divided phase does not advance.
- R8: While `idle_i` is high the core enable is low, and the peripheral enables keep their normal pattern.
- R9: A change of bit 0 written during power-down is applied at the first divided-phase rising edge after `pd_i` falls.
- R10: A write with `cfg_we_i` high loads bits 6..0 of `cfg_wdata_i` at the next clock edge. Bit 7 is reserved and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_fast_i | input | 1 | Hardware option: start in double-speed mode |
| pd_i | input | 1 | Power-down request: stop all enables |
| idle_i | input | 1 | Idle request: stop the core enable only |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_q_o | output | 8 | Current configuration register |
| cpu_en_o | output | 1 | Core clock enable |
| per_en_o | output | 6 | Peripheral enables: bit 0 timer 0 ... bit 5 watchdog |

## Verification
The bench writes the global speed bit in the cycle right after a core pulse. This exposes a design that switches speed at once: it would show a core pulse in the very next cycle instead of a gap.

Power-down is entered on the odd phase, and the mode bit is changed while frozen. After resume, the bench expects one gap and then continuous pulses. A divider that keeps toggling during power-down, or a mode latch that samples while frozen, would produce the wrong sequence.

Pulse counts over fixed windows catch these faults:
- peripheral speed bits leaking into standard mode;
- inverted speed-bit polarity;
- idle silencing the peripherals;
- a writable reserved bit;
- a wrong boot-mode reset value.

// File: rtl/dual_rate_clken_pkg.sv
package dual_rate_clken_pkg;
  localparam int NPER_DEF = 6;
  localparam int IDX_T0   = 0;
  localparam int IDX_T1   = 1;
  localparam int IDX_T2   = 2;
  localparam int IDX_SER  = 3;
  localparam int IDX_CNT  = 4;
  localparam int IDX_WDG  = 5;
endpackage

// File: rtl/drc_phase.sv
module drc_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic half_q_o,
  output logic half_en_o,
  output logic full_en_o
);
  logic half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    half_q <= 1'b0;
    else if (run_i) half_q <= ~half_q;
  end

  assign half_q_o  = half_q;
  assign half_en_o = run_i & ~half_q;
  assign full_en_o = run_i;

  AST_HALF_ALTERNATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_en_o |=> !half_en_o); // R1
  AST_PHASE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(half_q)); // R7
endmodule

// File: rtl/drc_mode_sync.sv
module drc_mode_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic boot_fast_i,
  input  logic want_fast_i,
  input  logic rise_i,
  output logic fast_o
);
  logic fast_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fast_q <= boot_fast_i;
    else if (rise_i) fast_q <= want_fast_i;
  end

  assign fast_o = fast_q;

  AST_MODE_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fast_q) |-> $past(rise_i)); // R3
endmodule

// File: rtl/drc_en_mux.sv
module drc_en_mux #(
  parameter int NPER = 6
) (
  input  logic            half_en_i,
  input  logic            full_en_i,
  input  logic            fast_i,
  input  logic            idle_i,
  input  logic [NPER-1:0] slow_sel_i,
  output logic            cpu_en_o,
  output logic [NPER-1:0] per_en_o
);
  assign cpu_en_o = ~idle_i & (fast_i ? full_en_i : half_en_i);

  for (genvar k = 0; k < NPER; k++) begin : g_per
    logic use_full;
    assign use_full    = fast_i & ~slow_sel_i[k];
    assign per_en_o[k] = use_full ? full_en_i : half_en_i;
  end
endmodule

// File: rtl/dual_rate_clken.sv
module dual_rate_clken
  import dual_rate_clken_pkg::*;
#(
  parameter int NPER  = NPER_DEF,
  localparam int CFG_W = NPER + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boot_fast_i,
  input  logic             pd_i,
  input  logic             idle_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_q_o,
  output logic             cpu_en_o,
  output logic [NPER-1:0]  per_en_o
);
  logic [CFG_W-1:0] cfg_q;
  logic run, half_q, half_en, full_en, fast;

  // bit 0 global speed, bits NPER..1 peripheral speed, top bit reserved
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= {{(CFG_W-1){1'b0}}, boot_fast_i};
    else if (cfg_we_i) cfg_q <= {1'b0, cfg_wdata_i[CFG_W-2:0]};
  end

  assign cfg_q_o = cfg_q;
  assign run     = ~pd_i;

  drc_phase u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .half_q_o  (half_q),
    .half_en_o (half_en),
    .full_en_o (full_en)
  );

  drc_mode_sync u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boot_fast_i (boot_fast_i),
    .want_fast_i (cfg_q[0]),
    .rise_i      (half_en),
    .fast_o      (fast)
  );

  drc_en_mux #(.NPER(NPER)) u_mux (
    .half_en_i  (half_en),
    .full_en_i  (full_en),
    .fast_i     (fast),
    .idle_i     (idle_i),
    .slow_sel_i (cfg_q[NPER:1]),
    .cpu_en_o   (cpu_en_o),
    .per_en_o   (per_en_o)
  );

  AST_PD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |-> (!cpu_en_o && per_en_o == '0)); // R7
  AST_IDLE_CPU_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> !cpu_en_o); // R8
  AST_RSV_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !cfg_q_o[CFG_W-1]); // R10
  AST_HALF_IDLE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_i == 1'b0 && half_q == 1'b0) |-> per_en_o == {NPER{1'b1}}); // R1
endmodule

// File: tb/dual_rate_clken_tb.sv
module dual_rate_clken_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0, boot = 1'b0, pd = 1'b0, idle = 1'b0, we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] cfg_q;
  logic cpu_en;
  logic [5:0] per_en;
  int checks = 0, errors = 0;
  int cpu_cnt;
  int per_cnt [6];

  always #5 clk = ~clk;

  dual_rate_clken u_dut (
    .clk_i(clk), .rst_ni(rst_n), .boot_fast_i(boot), .pd_i(pd), .idle_i(idle),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .cfg_q_o(cfg_q),
    .cpu_en_o(cpu_en), .per_en_o(per_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [7:0] d);
    we = 1'b1; wdata = d; step(); we = 1'b0;
  endtask

  task automatic count(input int n);
    cpu_cnt = 0;
    for (int k = 0; k < 6; k++) per_cnt[k] = 0;
    for (int i = 0; i < n; i++) begin
      #1;
      cpu_cnt += int'(cpu_en);
      for (int k = 0; k < 6; k++) per_cnt[k] += int'(per_en[k]);
      step();
    end
  endtask

  task automatic wait_cpu_pulse();
    for (int i = 0; i < 4 && !cpu_en; i++) step();
  endtask

  task automatic do_reset(input logic b);
    rst_n = 1'b0; boot = b;
    repeat (2) step();
    rst_n = 1'b1; #1;
    chk("R2 cfg reset", int'(cfg_q), int'({7'b0, b}));
    chk("R1 first pulse after reset", int'(cpu_en), 1);
    step();
  endtask

  task automatic t_std();
    count(8);
    chk("R1 std cpu count", cpu_cnt, 4);
    for (int k = 0; k < 6; k++) chk("R1 std per count", per_cnt[k], 4);
  endtask

  task automatic t_switch_timing();
    wait_cpu_pulse();
    we = 1'b1; wdata = 8'h01; step(); we = 1'b0;
    #1 chk("R3 no early switch", int'(cpu_en), 0);
    step(); #1 chk("R3 std pulse before switch", int'(cpu_en), 1);
    for (int i = 0; i < 3; i++) begin
      step(); #1 chk("R3 fast after rise edge", int'(cpu_en), 1);
    end
    step();
  endtask

  task automatic t_fast();
    count(8);
    chk("R4 fast cpu count", cpu_cnt, 8);
    for (int k = 0; k < 6; k++) chk("R5 clear bit full rate", per_cnt[k], 8);
  endtask

  task automatic t_per_sel();
    wr(8'h2B); step();
    count(8);
    chk("R5 t0 halved", per_cnt[0], 4);
    chk("R5 t1 full", per_cnt[1], 8);
    chk("R5 t2 halved", per_cnt[2], 4);
    chk("R5 serial full", per_cnt[3], 8);
    chk("R5 counter halved", per_cnt[4], 4);
    chk("R5 watchdog full", per_cnt[5], 8);
  endtask

  task automatic t_idle();
    idle = 1'b1;
    count(8);
    chk("R8 idle cpu silent", cpu_cnt, 0);
    chk("R8 idle per t1 runs", per_cnt[1], 8);
    chk("R8 idle per t0 runs", per_cnt[0], 4);
    idle = 1'b0;
  endtask

  task automatic t_reserved();
    wr(8'hFF); #1;
    chk("R10 reserved bit reads 0", int'(cfg_q), 8'h7F);
  endtask

  task automatic t_std_ignore();
    wr(8'h00); repeat (3) step();
    wr(8'h7E); #1;
    chk("R10 write loads", int'(cfg_q), 8'h7E);
    step();
    count(8);
    chk("R6 std cpu count", cpu_cnt, 4);
    for (int k = 0; k < 6; k++) chk("R6 per bits ignored in std", per_cnt[k], 4);
    wr(8'h00); step();
    count(8);
    for (int k = 0; k < 6; k++) chk("R6 clear bits in std", per_cnt[k], 4);
  endtask

  task automatic t_pd();
    wait_cpu_pulse();
    step();
    pd = 1'b1; #1;
    chk("R7 pd cpu", int'(cpu_en), 0);
    chk("R7 pd per", int'(per_en), 0);
    wr(8'h01);
    count(5);
    chk("R7 pd cpu count", cpu_cnt, 0);
    for (int k = 0; k < 6; k++) chk("R7 pd per count", per_cnt[k], 0);
    pd = 1'b0;
    #1 chk("R9 resume phase held", int'(cpu_en), 0);
    step(); #1 chk("R9 std pulse at resume rise", int'(cpu_en), 1);
    for (int i = 0; i < 3; i++) begin
      step(); #1 chk("R9 fast after resume", int'(cpu_en), 1);
    end
    step();
  endtask

  task automatic t_boot();
    do_reset(1'b1);
    count(8);
    chk("R2 boot fast cpu count", cpu_cnt, 8);
    chk("R2 boot fast per count", per_cnt[0], 8);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    t_std();
    t_switch_timing();
    t_fast();
    t_per_sel();
    t_idle();
    t_reserved();
    t_std_ignore();
    t_pd();
    t_boot();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule